// File: doc/BRIEF.md
# Aligned Block Loader for a Two-Dimensional Pixel Store

This block fills a matrix of A×B byte-wide memory modules from an external memory that keeps pixels in scan-line order on a bus W bytes wide. A pixel at row x and column y sits at linear byte address x·LH + y, where LH is the number of pixels per stored line. A caller gives the top-left coordinates of an aligned A×B block. The loader then requests the block's words from the linear memory, one per cycle, and writes each returned word into W adjacent modules of one module row.

Because only aligned blocks are moved, every module touched by one request shares a single intramodule address. A module row select and a column group select together pick the W modules that receive a word. The byte order on the bus is big-endian: the first pixel of a word is in its top byte. A one-cycle done pulse marks the end of the load. After that, the read side can fetch any A×B window from the modules in parallel.

Top module: `blk_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rd_req, wr_row_en, wr_col_en and done are all zero.
- R2: An accepted start produces exactly A·B/W cycles with rd_req high, one request per cycle. They begin in the cycle after the start is sampled and run without gaps.
- R3: Request k (counting from 0) of a block at aligned coordinates (i,j) carries the word address ((i + k/G)·LH + j + (k mod G)·W)/W, where G = B/W.
- R4: The n-th accepted rd_valid (counting from 0) produces one write cycle, in the next cycle. In that cycle wr_row_en is one-hot at bit n/G and wr_col_en is one-hot at bit n mod G. Both are zero in every other cycle.
- R5: Every write of a block carries wr_addr = (i/A)·(LH/B) + j/B.
- R6: wr_data equals the accepted word. Byte wr_data[8W-1-8k -: 8] belongs to module column g·W + k, so the top byte goes to the lowest column of the group.
- R7: done is high for exactly one cycle: the cycle right after the block's last write cycle.
- R8: A start that arrives while a block is in progress has no effect. It neither changes the block being loaded nor causes any later request.
- R9: The low log2(A) bits of start_row and the low log2(B) bits of start_col are ignored, so the block loaded is the aligned block that contains the given pixel.
- R10: After a load, every pixel (x,y) of the block is stored in module (x mod A, y mod B) at intramodule address (x/A)·(LH/B) + y/B, with the value it holds in the linear memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load request, sampled while idle |
| start_row | input | log2(LV) | Row coordinate of the block |
| start_col | input | log2(LH) | Column coordinate of the block |
| rd_req | output | 1 | Linear memory word request |
| rd_addr | output | log2(LH·LV/W) | Linear word address |
| rd_valid | input | 1 | Read data valid, returned in request order |
| rd_data | input | 8W | Read word, first pixel in the top byte |
| wr_row_en | output | A | Module row write select |
| wr_col_en | output | B/W | Module column group write select |
| wr_addr | output | log2(LH·LV/(A·B)) | Common intramodule write address |
| wr_data | output | 8W | Bytes for the selected module group |
| done | output | 1 | One-cycle completion pulse |

## Verification
Blocks are loaded at random aligned positions and at the two extreme corners of the store. Each load runs both with read data returned at once and with random gaps in rd_valid. Mixing these patterns separates the issue counter from the return counter, because requests run ahead of writes when data is delayed. Starts with unaligned coordinates test that the low coordinate bits are dropped. A second start pulsed during a load tests that the transfer in progress is not disturbed and that no extra request is queued. The module contents are then compared byte by byte against the scan-line array, using the read-side mapping of row mod A, column mod B and the module address.

// File: rtl/blk_loader.sv
module blk_loader #(
  parameter int A  = 2,
  parameter int B  = 4,
  parameter int W  = 2,
  parameter int LH = 64,
  parameter int LV = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [$clog2(LV)-1:0]               start_row,
  input  logic [$clog2(LH)-1:0]               start_col,
  output logic                                rd_req,
  output logic [$clog2(LH*LV/W)-1:0]          rd_addr,
  input  logic                                rd_valid,
  input  logic [8*W-1:0]                      rd_data,
  output logic [A-1:0]                        wr_row_en,
  output logic [B/W-1:0]                      wr_col_en,
  output logic [$clog2(LH*LV/(A*B))-1:0]      wr_addr,
  output logic [8*W-1:0]                      wr_data,
  output logic                                done
);
  localparam int G    = B / W;
  localparam int NW   = A * G;
  localparam int RW   = $clog2(LV);
  localparam int CW   = $clog2(LH);
  localparam int AW   = $clog2(LH*LV/W);
  localparam int MW   = $clog2(LH*LV/(A*B));
  localparam int CNTW = $clog2(NW + 1);

  logic            busy;
  logic [RW-1:0]   base_row;
  logic [CW-1:0]   base_col;
  logic [CNTW-1:0] iss_cnt, ret_cnt;
  logic [31:0]     ic, rc, iss_lin, iss_g;
  logic [RW-1:0]   al_row;
  logic [CW-1:0]   al_col;
  logic [MW-1:0]   blk_addr;

  assign al_row   = start_row & ~RW'(A - 1);
  assign al_col   = start_col & ~CW'(B - 1);
  assign blk_addr = MW'((32'(start_row) / A) * (LH / B) + 32'(start_col) / B);

  assign ic      = 32'(iss_cnt);
  assign rc      = 32'(ret_cnt);
  assign iss_g   = ic % G;
  assign iss_lin = (32'(base_row) + ic / G) * LH + 32'(base_col) + iss_g * W;
  assign rd_req  = busy && (iss_cnt < CNTW'(NW));
  assign rd_addr = AW'(iss_lin / W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      base_row  <= '0;
      base_col  <= '0;
      iss_cnt   <= '0;
      ret_cnt   <= '0;
      wr_row_en <= '0;
      wr_col_en <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      done      <= 1'b0;
    end else begin
      done      <= 1'b0;
      wr_row_en <= '0;
      wr_col_en <= '0;
      if (!busy && start) begin
        busy     <= 1'b1;
        base_row <= al_row;
        base_col <= al_col;
        iss_cnt  <= '0;
        ret_cnt  <= '0;
        wr_addr  <= blk_addr;
      end
      if (busy) begin
        if (rd_req) iss_cnt <= iss_cnt + 1'b1;
        if (rd_valid && ret_cnt < CNTW'(NW)) begin
          wr_row_en <= A'(1) << (rc / G);
          wr_col_en <= G'(1) << (rc % G);
          wr_data   <= rd_data;
          ret_cnt   <= ret_cnt + 1'b1;
        end
        if (ret_cnt == CNTW'(NW)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(|wr_row_en));

  a_r4_enables_paired: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_row_en) && $onehot0(wr_col_en) && ((|wr_row_en) == (|wr_col_en)));

  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_row_en) && $past(|wr_row_en)) |-> $stable(wr_addr));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req) && iss_g != 0) |-> rd_addr == $past(rd_addr) + 1'b1);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(base_row) && $stable(base_col)));
endmodule

// File: tb/blk_loader_tb_top.sv
module blk_loader_tb_top;
  localparam int A = 2, B = 4, W = 2, LH = 64, LV = 32;
  localparam int G = B / W, NW = A * G, MD = LH * LV / (A * B);

  logic clk = 0, rst_n = 0, start = 0, rd_valid = 0;
  logic [$clog2(LV)-1:0] start_row = '0;
  logic [$clog2(LH)-1:0] start_col = '0;
  logic rd_req, done;
  logic [$clog2(LH*LV/W)-1:0] rd_addr;
  logic [8*W-1:0] rd_data = '0, wr_data;
  logic [A-1:0] wr_row_en;
  logic [G-1:0] wr_col_en;
  logic [$clog2(MD)-1:0] wr_addr;

  blk_loader #(.A(A), .B(B), .W(W), .LH(LH), .LV(LV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row), .start_col(start_col),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_row_en(wr_row_en), .wr_col_en(wr_col_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] lin [LH*LV];
  logic [7:0] mm [A*B*MD];
  bit         wrt [A*B*MD];
  int q[$];
  bit stall_mode = 0;
  int er, ec, req_n, first_req, last_req, wr_n, last_wr, done_n, done_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_word(int k);
    return ((er + k / G) * LH + ec + (k % G) * W) / W;
  endfunction

  always @(negedge clk) begin
    if (rd_req) begin
      chk(rd_addr == exp_word(req_n), "R3", rd_addr, exp_word(req_n));
      if (req_n == 0) first_req = cyc;
      last_req = cyc;
      req_n++;
      q.push_back(int'(rd_addr));
    end
    if (|wr_row_en) begin
      int r, g;
      r = 0; g = 0;
      for (int t = 0; t < A; t++) if (wr_row_en[t]) r = t;
      for (int t = 0; t < G; t++) if (wr_col_en[t]) g = t;
      chk(r == wr_n / G && g == wr_n % G, "R4", r * G + g, wr_n);
      chk(wr_addr == (er / A) * (LH / B) + ec / B, "R5", wr_addr, (er / A) * (LH / B) + ec / B);
      for (int k = 0; k < W; k++) begin
        int idx;
        idx = (r * B + g * W + k) * MD + int'(wr_addr);
        mm[idx]  = wr_data[8*(W-1-k) +: 8];
        wrt[idx] = 1;
      end
      wr_n++;
      last_wr = cyc;
    end
    if (done) begin
      done_n++;
      done_cyc = cyc;
    end
    if (q.size() > 0 && (!stall_mode || ($urandom % 3) != 0)) begin
      int a;
      a = q.pop_front();
      rd_valid = 1;
      for (int k = 0; k < W; k++) rd_data[8*(W-1-k) +: 8] = lin[a * W + k];
    end else begin
      rd_valid = 0;
    end
  end

  task automatic clear_state(int row, int col);
    er = row & ~(A - 1); ec = col & ~(B - 1);
    req_n = 0; wr_n = 0; done_n = 0; first_req = -1; last_req = -1; last_wr = -1; done_cyc = -1;
    for (int t = 0; t < A*B*MD; t++) wrt[t] = 0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (done_n == 0 && n < 200) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_block(int st_cyc, string rq);
    chk(req_n == NW, "R2", req_n, NW);
    chk(first_req == st_cyc && last_req == st_cyc + NW - 1, "R2", last_req - first_req, NW - 1);
    chk(wr_n == NW, "R4", wr_n, NW);
    chk(done_n == 1 && done_cyc == last_wr + 1, "R7", done_cyc, last_wr + 1);
    for (int x = er; x < er + A; x++)
      for (int y = ec; y < ec + B; y++) begin
        int idx;
        idx = ((x % A) * B + (y % B)) * MD + (x / A) * (LH / B) + y / B;
        chk(wrt[idx] && mm[idx] == lin[x * LH + y], rq, int'(mm[idx]), int'(lin[x * LH + y]));
      end
  endtask

  task automatic load(int row, int col, string rq);
    int st;
    clear_state(row, col);
    start_row = row[$clog2(LV)-1:0]; start_col = col[$clog2(LH)-1:0]; start = 1;
    @(negedge clk); start = 0; st = cyc;
    wait_done();
    check_block(st, rq);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int t = 0; t < LH*LV; t++) lin[t] = 8'((t * 37 + 11) ^ (t >> 7));
    repeat (3) @(negedge clk);
    chk(!rd_req && wr_row_en == 0 && wr_col_en == 0 && !done, "R1", int'(rd_req) + int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_req && wr_row_en == 0 && wr_col_en == 0 && !done, "R1", int'(rd_req) + int'(done), 0);

    load(0, 0, "R10");
    load(LV - A, LH - B, "R10");
    stall_mode = 1;
    load(LV - A, LH - B, "R6");
    load(5, 7, "R9");
    load(3, 62, "R9");
    for (int n = 0; n < 40; n++) begin
      stall_mode = n[0];
      load(int'($urandom % LV) & ~(A - 1), int'($urandom % LH) & ~(B - 1), "R10");
    end

    begin : r8_test
      int st;
      stall_mode = 1;
      clear_state(8, 16);
      start_row = 8; start_col = 16; start = 1;
      @(negedge clk); start = 0; st = cyc;
      @(negedge clk);
      start_row = 20; start_col = 40; start = 1;
      @(negedge clk); start = 0;
      wait_done();
      check_block(st, "R8");
      req_n = 0;
      repeat (10) @(negedge clk);
      chk(req_n == 0, "R8", req_n, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule